// File: doc/BRIEF.md
# Banked Shared Memory Conflict Arbiter

This block serves one group of sixteen lane requests to a word-addressed shared memory built from sixteen single-port banks of 32-bit words, 4096 words in total. Each lane brings a word address, a valid bit and write data. One group-level flag says whether the whole group reads or writes. The arbiter steers each address to a bank and spots lanes that collide on a bank. It then runs as many bank passes as the most crowded bank needs, and raises a one-cycle completion pulse once every lane has been served. Lanes that name the very same word are folded into a single access.

The control is a four-state machine. In `ST_IDLE` the block waits with `busy` low. A `start` pulse latches the group (transition *accept*) and moves to `ST_SERVE`. In `ST_SERVE` every bank serves one address per cycle. The machine stays there while any lane is still pending (transition *more passes*). It leaves for `ST_DRAIN` after the final pass (transition *last pass*). In `ST_DRAIN` the read data of the final pass is captured into the lane result registers. `ST_DONE` follows unconditionally (transition *drained*). In `ST_DONE` the `done` output is high for one cycle, and the machine then returns to `ST_IDLE` (transition *release*).

Top module: `smem_arbiter`

## Requirements
- R1: A word address A selects bank A mod 16 and row A div 16 inside that bank; every one of the 4096 word addresses holds its own independent word.
- R2: Taking the accepting clock edge as edge 0 and S as the number of passes, `busy` is high after edges 0 through S+1, `done` is high only after edge S+1, and both are low after edge S+2.
- R3: A group whose valid lanes all fall in different banks completes in one pass (S = 1).
- R4: A group whose valid lanes all name one identical address completes in one pass, and every valid lane receives that word.
- R5: S equals the largest count of distinct addresses that the valid lanes send to any single bank: a word stride of 2 gives 2 passes, a stride of 8 gives 8 passes, and an odd stride gives 1 pass.
- R6: Within a bank, distinct addresses are served in ascending order of their lowest requesting lane. All lanes that share an address are served in the same pass and receive identical read data.
- R7: When several lanes of a write group target one address, the data of the highest-numbered of those lanes is what is stored.
- R8: A `start` that arrives while `busy` is high is ignored. The current group's timing and results are unchanged, and no second group begins.
- R9: When `done` is high, `rdata` lane L (bits 32L+31..32L) holds the stored word for each valid lane of a read group. It holds zero for invalid lanes and for every lane of a write group. `rdata` then holds its value until the next accepted `start`.
- R10: After reset, `busy`, `done` and all of `rdata` are low.
- R11: A group with no valid lane still takes one pass (S = 1) and returns all-zero `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Offer a new group; taken only while `busy` is low |
| grp_write | input | 1 | 1: the group writes, 0: the group reads |
| lane_valid | input | 16 | Per-lane request valid, bit L for lane L |
| lane_addr | input | 192 | Lane L word address in bits 12L+11..12L |
| lane_wdata | input | 512 | Lane L write word in bits 32L+31..32L |
| busy | output | 1 | A group is in progress |
| done | output | 1 | One-cycle pulse; `rdata` is complete |
| rdata | output | 512 | Lane L read word in bits 32L+31..32L |

## Verification
A wrong pending mask or bank pick shows at the ports as a `done` pulse that comes early or late. This can be seen within the one group where it happens, because the pass count is predictable from the addresses alone. A fault in the bank or row split, in the merging of equal addresses or in the write winner stays inside the storage. It surfaces only when a later read group returns a word that differs from the reference memory. For that reason, every write pattern is followed by reads that cover the same words. A fault in the capture path corrupts `rdata` in the `done` cycle. A fault in the hold logic corrupts `rdata` in the cycle after `done`.

// File: rtl/smem_pkg.sv
package smem_pkg;
    parameter int LANES = 16;
    parameter int BANKS = 16;
    parameter int DW    = 32;
    parameter int AW    = 12;

    localparam int BW    = $clog2(BANKS);
    localparam int RW    = AW - BW;
    localparam int DEPTH = 1 << RW;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SERVE = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } arb_state_t;
endpackage

// File: rtl/bank_select.sv
// Picks, for one bank, the address served in this pass and the lanes it covers.
module bank_select #(
    parameter int LANES = 16,
    parameter int BW    = 4,
    parameter int RW    = 8,
    parameter int DW    = 32,
    parameter int BANK  = 0
) (
    input  logic [LANES-1:0]          pend,
    input  logic [LANES*(BW+RW)-1:0]  addr,
    input  logic [LANES*DW-1:0]       wdata,
    output logic                      en,
    output logic [RW-1:0]             row,
    output logic [DW-1:0]             wd,
    output logic [LANES-1:0]          take
);
    localparam int AW = BW + RW;

    logic [LANES-1:0] hit;

    always_comb begin
        en   = 1'b0;
        row  = '0;
        wd   = '0;
        take = '0;
        for (int l = 0; l < LANES; l++) begin
            hit[l] = pend[l] && (addr[l*AW +: BW] == BW'(BANK));
        end
        // lowest pending lane of this bank chooses the row (R6)
        for (int l = LANES - 1; l >= 0; l--) begin
            if (hit[l]) begin
                en  = 1'b1;
                row = addr[l*AW + BW +: RW];
            end
        end
        // every lane naming that row is merged; highest one supplies write data (R7)
        for (int l = 0; l < LANES; l++) begin
            if (hit[l] && (addr[l*AW + BW +: RW] == row)) begin
                take[l] = 1'b1;
                wd      = wdata[l*DW +: DW];
            end
        end
    end
endmodule

// File: rtl/bank_store.sv
// One single-port bank with a registered read.
module bank_store #(
    parameter int RW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [RW-1:0] row,
    input  logic [DW-1:0] wd,
    output logic [DW-1:0] rd
);
    localparam int DEPTH = 1 << RW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[row] <= wd;
            end else begin
                rd <= mem[row];
            end
        end
    end
endmodule

// File: rtl/smem_arbiter.sv
module smem_arbiter
    import smem_pkg::*;
#(
    parameter int LANES = smem_pkg::LANES,
    parameter int BANKS = smem_pkg::BANKS,
    parameter int DW    = smem_pkg::DW,
    parameter int AW    = smem_pkg::AW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                grp_write,
    input  logic [LANES-1:0]    lane_valid,
    input  logic [LANES*AW-1:0] lane_addr,
    input  logic [LANES*DW-1:0] lane_wdata,
    output logic                busy,
    output logic                done,
    output logic [LANES*DW-1:0] rdata
);
    localparam int LBW = $clog2(BANKS);
    localparam int LRW = AW - LBW;

    arb_state_t st, st_nx;

    logic [LANES-1:0]    pend_q, cap_q, served, pend_eff, left;
    logic [LANES*AW-1:0] addr_q;
    logic [LANES*DW-1:0] wdata_q;
    logic                wr_q;
    logic                accept;

    logic [BANKS-1:0]    en_b;
    logic [LRW-1:0]      row_b  [BANKS];
    logic [DW-1:0]       wd_b   [BANKS];
    logic [DW-1:0]       rd_b   [BANKS];
    logic [LANES-1:0]    take_b [BANKS];

    assign pend_eff = (st == ST_SERVE) ? pend_q : '0;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        bank_select #(
            .LANES(LANES), .BW(LBW), .RW(LRW), .DW(DW), .BANK(b)
        ) u_sel (
            .pend  (pend_eff),
            .addr  (addr_q),
            .wdata (wdata_q),
            .en    (en_b[b]),
            .row   (row_b[b]),
            .wd    (wd_b[b]),
            .take  (take_b[b])
        );
        bank_store #(.RW(LRW), .DW(DW)) u_store (
            .clk (clk),
            .en  (en_b[b]),
            .we  (wr_q),
            .row (row_b[b]),
            .wd  (wd_b[b]),
            .rd  (rd_b[b])
        );
    end

    always_comb begin
        served = '0;
        for (int b = 0; b < BANKS; b++) begin
            served = served | take_b[b];
        end
        left = pend_q & ~served;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // next state and outputs
    always_comb begin
        st_nx  = st;
        busy   = 1'b1;
        done   = 1'b0;
        accept = 1'b0;
        unique case (st)
            ST_IDLE: begin
                busy = 1'b0;
                if (start) begin
                    accept = 1'b1;
                    st_nx  = ST_SERVE;
                end
            end
            ST_SERVE: begin
                if (left == '0) begin
                    st_nx = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                st_nx = ST_DONE;
            end
            ST_DONE: begin
                done  = 1'b1;
                st_nx = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // group registers and result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= '0;
            cap_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
            rdata   <= '0;
        end else if (accept) begin
            pend_q  <= lane_valid;
            cap_q   <= '0;
            addr_q  <= lane_addr;
            wdata_q <= lane_wdata;
            wr_q    <= grp_write;
            rdata   <= '0;
        end else begin
            pend_q <= left;
            cap_q  <= wr_q ? '0 : served;
            for (int l = 0; l < LANES; l++) begin
                if (cap_q[l]) begin
                    rdata[l*DW +: DW] <= rd_b[addr_q[l*AW +: LBW]];
                end
            end
        end
    end
endmodule

// File: rtl/smem_arbiter_chk.sv
module smem_arbiter_chk #(
    parameter int RDW = 512
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic [RDW-1:0] rdata
);
    // R2
    done_one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R2
    busy_ends_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R8
    start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !done));

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(rdata));

    // R9
    rdata_hold_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(rdata));
endmodule

bind smem_arbiter smem_arbiter_chk #(.RDW(LANES*DW)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .rdata (rdata)
);

// File: tb/tb_smem_arbiter.sv
module tb_smem_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 16;
    localparam int NW = 4096;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            grp_write = 1'b0;
    logic [NL-1:0]   lane_valid = '0;
    logic [NL*12-1:0] lane_addr = '0;
    logic [NL*32-1:0] lane_wdata = '0;
    logic            busy, done;
    logic [NL*32-1:0] rdata;

    int total = 0;
    int bad = 0;

    logic [31:0] ref_mem [NW];
    logic [11:0] ta [NL];
    logic [31:0] td [NL];
    logic [NL-1:0] tv;
    logic          twr;

    always #(CLK_PERIOD/2) clk = ~clk;

    smem_arbiter dut (
        .clk(clk), .rst_n(rst_n), .start(start), .grp_write(grp_write),
        .lane_valid(lane_valid), .lane_addr(lane_addr), .lane_wdata(lane_wdata),
        .busy(busy), .done(done), .rdata(rdata)
    );

    task automatic chk(input bit ok, input string rq, input logic [NL*32-1:0] act,
                       input logic [NL*32-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic int passes_needed();
        int worst = 1;
        for (int b = 0; b < 16; b++) begin
            int cnt = 0;
            for (int i = 0; i < NL; i++) begin
                bit fresh = 1'b1;
                if (!tv[i] || (ta[i] % 16) != b) continue;
                for (int j = 0; j < i; j++)
                    if (tv[j] && ta[j] == ta[i]) fresh = 1'b0;
                if (fresh) cnt++;
            end
            if (cnt > worst) worst = cnt;
        end
        return worst;
    endfunction

    // Run one group; exp_s < 0 means no stated pass count. poke drives a start while busy.
    task automatic run_group(input string rq, input int exp_s, input bit poke);
        logic [NL*32-1:0] exp_rd = '0;
        int s = passes_needed();
        if (exp_s >= 0)
            chk(s == exp_s, {rq, " pass count"}, NL*32'(s), NL*32'(exp_s));
        for (int i = 0; i < NL; i++)
            if (!twr && tv[i]) exp_rd[i*32 +: 32] = ref_mem[ta[i]];
        if (twr)
            for (int i = 0; i < NL; i++)
                if (tv[i]) ref_mem[ta[i]] = td[i];
        @(negedge clk);
        for (int i = 0; i < NL; i++) begin
            lane_addr[i*12 +: 12]  = ta[i];
            lane_wdata[i*32 +: 32] = td[i];
        end
        lane_valid = tv;
        grp_write  = twr;
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k <= s + 2; k++) begin
            if (poke && k == 1) begin
                start      = 1'b1;
                grp_write  = ~twr;
                lane_valid = '1;
                lane_addr  = ~lane_addr;
                lane_wdata = ~lane_wdata;
            end
            if (poke && k == 2) start = 1'b0;
            chk(busy == (k <= s + 1), {rq, " busy"}, NL*32'(busy), NL*32'(k <= s + 1));
            chk(done == (k == s + 1), {rq, " done"}, NL*32'(done), NL*32'(k == s + 1));
            if (k >= s + 1)
                chk(rdata == exp_rd, {rq, " rdata"}, rdata, exp_rd);
            if (k < s + 2) @(negedge clk);
        end
    endtask

    task automatic set_stride(input int base, input int stride, input bit wr);
        for (int i = 0; i < NL; i++) begin
            ta[i] = 12'(base + stride * i);
            td[i] = 32'h5A00_0000 ^ (32'(base + stride * i) * 32'h0001_0103);
        end
        tv  = '1;
        twr = wr;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NW; i++) ref_mem[i] = 'x;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(!busy && !done && rdata == '0, "R10 reset", rdata, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done, "R10 idle after reset", NL*32'({busy, done}), '0);

        // fill rows 0..31 and the top row with stride-1 write groups: R1, R3
        for (int g = 0; g < 32; g++) begin
            set_stride(g * 16, 1, 1'b1);
            run_group("R3 R9 write fill", 1, 1'b0);
        end
        set_stride(4080, 1, 1'b1);
        run_group("R1 write top row", 1, 1'b0);

        // R1 R3 stride-1 read
        set_stride(32, 1, 1'b0);
        run_group("R1 R3 read stride1", 1, 1'b0);
        set_stride(4080, 1, 1'b0);
        run_group("R1 read top row", 1, 1'b0);

        // R5 odd stride, stride 2, stride 8
        set_stride(5, 3, 1'b0);
        run_group("R5 stride3", 1, 1'b0);
        set_stride(0, 2, 1'b0);
        run_group("R5 stride2", 2, 1'b0);
        set_stride(0, 8, 1'b0);
        run_group("R5 stride8", 8, 1'b0);
        set_stride(4, 16, 1'b0);
        run_group("R5 R1 same bank", 16, 1'b0);

        // R4 broadcast read
        for (int i = 0; i < NL; i++) begin ta[i] = 12'd77; td[i] = 0; end
        tv = '1; twr = 1'b0;
        run_group("R4 broadcast", 1, 1'b0);

        // R6 merge inside a bank: lanes 0,1,3 -> addr 0, lane 2 -> addr 16
        for (int i = 0; i < NL; i++) begin ta[i] = 12'd0; td[i] = 0; end
        ta[2] = 12'd16; tv = 16'h000F; twr = 1'b0;
        run_group("R6 merge", 2, 1'b0);

        // R7 same-address writes, highest lane wins, then read back
        for (int i = 0; i < NL; i++) begin ta[i] = 12'd200; td[i] = 32'hC0DE_0000 + 32'(i); end
        tv = '1; twr = 1'b1;
        run_group("R7 dup write", 1, 1'b0);
        tv = 16'h0011; twr = 1'b0;
        run_group("R7 readback", 1, 1'b0);
        for (int i = 0; i < NL; i++) begin ta[i] = 12'd300 + 12'(16 * (i % 2)); td[i] = 32'hBEEF_0000 + 32'(i); end
        tv = 16'h0F0F; twr = 1'b1;
        run_group("R7 R5 partial dup write", 2, 1'b0);
        tv = '1; twr = 1'b0;
        run_group("R7 readback pair", 2, 1'b0);

        // R8 start while busy ignored
        set_stride(1, 2, 1'b0);
        run_group("R8 start while busy", 2, 1'b1);
        set_stride(0, 1, 1'b0);
        run_group("R8 next group after poke", 1, 1'b0);

        // R11 empty group
        set_stride(0, 1, 1'b0);
        tv = '0;
        run_group("R11 empty", 1, 1'b0);

        // R9 partial read: invalid lanes return zero
        set_stride(64, 1, 1'b0);
        tv = 16'hA5C3;
        run_group("R9 partial read", 1, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule